// File: doc/BRIEF.md
# High-Speed Crystal Clock Failure Monitor

This block supervises a high-speed crystal clock from a reference clock domain. It runs on the internal reference clock. Each rising edge of the monitored clock flips a toggle flop, and a short synchronizer chain carries that toggle into the reference domain. A watchdog counter then measures how long the monitored clock has been silent. When the silence lasts too long, the monitor reacts on its own:

- It drops the crystal oscillator enable.
- It pulls the system clock off the crystal path onto one of two internal oscillators.
- It turns the PLL off when the PLL was both fed by the crystal and driving the system clock.
- It fires a one-cycle break pulse for timers.
- It latches a failure flag that drives a non-maskable interrupt until software clears it.

Software arms supervision with an enable level. The watchdog counts only after the oscillator reports ready and a further settle delay has passed. Software owns three registers held inside the block: the oscillator enable, the PLL enable and the system clock select. A failure overrides any software write to these registers in the same cycle.

Top module: `hse_fail_monitor`

## Requirements
- R1: While `css_en` is 0 the monitor never acts. A stopped monitored clock leaves `osc_en`, `pll_en`, `sys_sel`, `nmi` and `brk` unchanged.
- R2: The monitor becomes armed only after `ARM_DELAY` consecutive reference cycles in which `css_en`, `osc_en` and `osc_rdy` are all 1. If any of the three is 0 in a cycle, the monitor disarms and the delay starts again.
- R3: A failure is declared once the armed monitor has seen `MISS_LIMIT` consecutive reference cycles with no monitored edge arriving through the `SYNC_STAGES`-flop synchronizer. On the next reference edge `osc_en` becomes 0, and a clock that keeps running never causes a failure.
- R4: `brk` is high for exactly one cycle: the cycle in which `nmi` first rises for that failure.
- R5: `nmi` stays 1 until a cycle with `flag_clr`=1 and no new failure. A failure in the same cycle as `flag_clr` wins and sets the flag.
- R6: System clock select codes are 0 = internal oscillator A, 1 = internal oscillator B, 2 = crystal, 3 = PLL.
  - A failure forces a fallback when `sys_sel` is 2, or when `sys_sel` is 3 and `pll_src` is 2 (crystal, undivided) or 3 (crystal halved).
  - The fallback is `sys_sel`=0 when `wake_sel`=0 and `sys_sel`=1 when `wake_sel`=1.
  - The new value appears on `sys_sel` in the same cycle as `brk`.
- R7: On a failure, `pll_en` is cleared only if `sys_sel` was 3 and `pll_src` was 2 or 3. A crystal-fed PLL that is not driving the system clock stays enabled.
- R8: When the crystal is not in the system clock path, a failure leaves `sys_sel` unchanged. `osc_en` is still cleared, and `nmi` and `brk` still assert.
- R9: After a synchronous reset, `osc_en`, `pll_en`, `nmi` and `brk` are 0 and `sys_sel` is 0.
- R10: A write strobe (`osc_wr`, `pll_wr`, `sel_wr`) loads its data on the next reference edge, unless a failure overrides that field in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored crystal clock |
| css_en | input | 1 | Software enable for supervision |
| osc_rdy | input | 1 | Crystal oscillator ready |
| osc_wr | input | 1 | Write strobe for the oscillator enable |
| osc_wdata | input | 1 | Oscillator enable write value |
| pll_wr | input | 1 | Write strobe for the PLL enable |
| pll_wdata | input | 1 | PLL enable write value |
| sel_wr | input | 1 | Write strobe for the system clock select |
| sel_wdata | input | 2 | System clock select write value |
| pll_src | input | 2 | PLL input: 0/1 internal, 2 crystal, 3 crystal halved |
| wake_sel | input | 1 | Fallback choice: 0 oscillator A, 1 oscillator B |
| flag_clr | input | 1 | Clear strobe for the failure flag |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| sys_sel | output | 2 | System clock select and status |
| nmi | output | 1 | Sticky failure flag driving the NMI |
| brk | output | 1 | One-cycle timer break pulse |

## Verification
The bench builds the block with `ARM_DELAY`=4 and `MISS_LIMIT`=8, keeping the default two-stage synchronizer. With these values, arming, disarming on a ready glitch and a full silence window all fit within a few dozen cycles. That makes every select and PLL-source combination, and a clear held through a failure, affordable to cover. A monitored clock running at a quarter of the reference rate shows that a live clock never trips the counter.

// File: rtl/hfm_pkg.sv
package hfm_pkg;
  typedef enum logic [1:0] {
    SRC_INT_A = 2'd0,
    SRC_INT_B = 2'd1,
    SRC_XTAL  = 2'd2,
    SRC_PLL   = 2'd3
  } sysclk_e;

  function automatic logic pll_from_xtal(input logic [1:0] src);
    return (src == 2'd2) || (src == 2'd3);
  endfunction

  function automatic logic [1:0] fallback_code(input logic wake);
    return wake ? SRC_INT_B : SRC_INT_A;
  endfunction
endpackage

// File: rtl/hfm_edge_sync.sv
module hfm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_clk,
  output logic mon_edge
);
  localparam int SW = SYNC_STAGES + 1;

  logic          tog = 1'b0;
  logic [SW-1:0] sr;

  always_ff @(posedge mon_clk) tog <= ~tog;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[SW-2:0], tog};
  end

  assign mon_edge = sr[SW-1] ^ sr[SW-2];
endmodule

// File: rtl/hfm_arm.sv
module hfm_arm #(
  parameter int ARM_DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  output logic armed
);
  localparam int AW = (ARM_DELAY < 2) ? 1 : $clog2(ARM_DELAY + 1);

  logic [AW-1:0] acnt;

  always_ff @(posedge clk) begin
    if (rst || !cond) begin
      acnt  <= '0;
      armed <= 1'b0;
    end else if (!armed) begin
      if (acnt == AW'(ARM_DELAY - 1)) armed <= 1'b1;
      else                            acnt  <= acnt + 1'b1;
    end
  end

  assert_disarm_R2: assert property (@(posedge clk) disable iff (rst)
    !cond |=> !armed);
  assert_arm_needs_cond_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(cond));
endmodule

// File: rtl/hfm_watchdog.sv
module hfm_watchdog #(
  parameter int MISS_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic mon_edge,
  output logic fail
);
  localparam int CW = $clog2(MISS_LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !armed || mon_edge) cnt <= '0;
    else if (cnt != CW'(MISS_LIMIT))  cnt <= cnt + 1'b1;
  end

  assign fail = armed && !mon_edge && (cnt == CW'(MISS_LIMIT - 1));

  assert_single_fail_R3: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail);
endmodule

// File: rtl/hse_fail_monitor.sv
module hse_fail_monitor
  import hfm_pkg::*;
#(
  parameter int ARM_DELAY   = 16,
  parameter int MISS_LIMIT  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mon_clk,
  input  logic       css_en,
  input  logic       osc_rdy,
  input  logic       osc_wr,
  input  logic       osc_wdata,
  input  logic       pll_wr,
  input  logic       pll_wdata,
  input  logic       sel_wr,
  input  logic [1:0] sel_wdata,
  input  logic [1:0] pll_src,
  input  logic       wake_sel,
  input  logic       flag_clr,
  output logic       osc_en,
  output logic       pll_en,
  output logic [1:0] sys_sel,
  output logic       nmi,
  output logic       brk
);
  logic mon_edge, armed, fail, pll_path, xtal_path;

  hfm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .mon_clk(mon_clk), .mon_edge(mon_edge));

  hfm_arm #(.ARM_DELAY(ARM_DELAY)) u_arm (
    .clk(clk), .rst(rst), .cond(css_en && osc_en && osc_rdy), .armed(armed));

  hfm_watchdog #(.MISS_LIMIT(MISS_LIMIT)) u_wd (
    .clk(clk), .rst(rst), .armed(armed), .mon_edge(mon_edge), .fail(fail));

  assign pll_path  = (sys_sel == SRC_PLL) && pll_from_xtal(pll_src);
  assign xtal_path = (sys_sel == SRC_XTAL) || pll_path;

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_en  <= 1'b0;
      pll_en  <= 1'b0;
      sys_sel <= SRC_INT_A;
      nmi     <= 1'b0;
      brk     <= 1'b0;
    end else begin
      brk <= fail;
      if (fail)          nmi <= 1'b1;
      else if (flag_clr) nmi <= 1'b0;
      if (fail)          osc_en <= 1'b0;
      else if (osc_wr)   osc_en <= osc_wdata;
      if (fail && pll_path) pll_en <= 1'b0;
      else if (pll_wr)      pll_en <= pll_wdata;
      if (fail && xtal_path) sys_sel <= fallback_code(wake_sel);
      else if (sel_wr)       sys_sel <= sel_wdata;
    end
  end

  assert_osc_off_R3: assert property (@(posedge clk) disable iff (rst)
    fail |=> !osc_en);
  assert_brk_with_flag_R4: assert property (@(posedge clk) disable iff (rst)
    fail |=> (brk && nmi));
  assert_brk_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    brk |=> !brk);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (nmi && !flag_clr) |=> nmi);
  assert_fallback_R6: assert property (@(posedge clk) disable iff (rst)
    (fail && xtal_path) |=> (sys_sel == $past(fallback_code(wake_sel))));
  assert_pll_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (fail && !pll_path && !pll_wr && pll_en) |=> pll_en);
  assert_sel_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (fail && !xtal_path && !sel_wr) |=> $stable(sys_sel));
endmodule

// File: tb/hse_fail_monitor_test.sv
module hse_fail_monitor_test;
  localparam int ARM = 4;
  localparam int LIM = 8;

  logic clk = 1'b0, rst = 1'b1, mon_clk = 1'b0;
  logic css_en = 0, osc_rdy = 0, osc_wr = 0, osc_wdata = 0, pll_wr = 0, pll_wdata = 0;
  logic sel_wr = 0, wake_sel = 0, flag_clr = 0;
  logic [1:0] sel_wdata = 0, pll_src = 0;
  logic osc_en, pll_en, nmi, brk;
  logic [1:0] sys_sel;

  int tests = 0, fails = 0;
  int mcnt = 0;
  bit mon_run = 0, m_rise = 0;

  // behavioural reference state
  bit m_p1, m_p2, m_armed, m_osc, m_pll, m_flag, m_brk;
  int m_ac, m_cnt;
  logic [1:0] m_sel;

  hse_fail_monitor #(.ARM_DELAY(ARM), .MISS_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .mon_clk(mon_clk), .css_en(css_en), .osc_rdy(osc_rdy),
    .osc_wr(osc_wr), .osc_wdata(osc_wdata), .pll_wr(pll_wr), .pll_wdata(pll_wdata),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .pll_src(pll_src), .wake_sel(wake_sel),
    .flag_clr(flag_clr), .osc_en(osc_en), .pll_en(pll_en), .sys_sel(sys_sel),
    .nmi(nmi), .brk(brk));

  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitored clock: rises at a quarter of the reference rate, edges at negedge
  always @(negedge clk) begin
    mcnt++;
    m_rise = 0;
    if (mon_run) begin
      if (mcnt % 4 == 0) begin mon_clk = 1; m_rise = 1; end
      else if (mcnt % 4 == 2) mon_clk = 0;
    end else mon_clk = 0;
  end

  // reference model, compared every cycle
  always @(posedge clk) begin
    bit e, cond, f, ppath, xpath;
    if (rst) begin
      m_p1 = 0; m_p2 = 0; m_armed = 0; m_ac = 0; m_cnt = 0;
      m_osc = 0; m_pll = 0; m_sel = 0; m_flag = 0; m_brk = 0;
    end else begin
      e = m_p2; m_p2 = m_p1; m_p1 = m_rise;
      cond  = css_en && m_osc && osc_rdy;
      f     = m_armed && !e && (m_cnt == LIM - 1);
      ppath = (m_sel == 3) && (pll_src >= 2);
      xpath = (m_sel == 2) || ppath;
      if (!m_armed || e) m_cnt = 0;
      else if (m_cnt != LIM) m_cnt++;
      if (!cond) begin m_ac = 0; m_armed = 0; end
      else if (!m_armed) begin
        if (m_ac == ARM - 1) m_armed = 1; else m_ac++;
      end
      m_brk = f;
      if (f) m_flag = 1; else if (flag_clr) m_flag = 0;
      if (f) m_osc = 0; else if (osc_wr) m_osc = osc_wdata;
      if (f && ppath) m_pll = 0; else if (pll_wr) m_pll = pll_wdata;
      if (f && xpath) m_sel = wake_sel ? 2'd1 : 2'd0; else if (sel_wr) m_sel = sel_wdata;
    end
    #2;
    check("R3 osc_en", osc_en, m_osc);
    check("R7 pll_en", pll_en, m_pll);
    check("R6 sys_sel", sys_sel, m_sel);
    check("R5 nmi", nmi, m_flag);
    check("R4 brk", brk, m_brk);
  end

  task automatic load(input logic [1:0] sel, input logic [1:0] src, input logic wake,
                      input logic pll, input bit run);
    @(negedge clk);
    css_en = 0; osc_rdy = 1; osc_wr = 1; osc_wdata = 1; pll_wr = 1; pll_wdata = pll;
    sel_wr = 1; sel_wdata = sel; pll_src = src; wake_sel = wake; flag_clr = 1;
    mon_run = run;
    @(negedge clk);
    osc_wr = 0; pll_wr = 0; sel_wr = 0; flag_clr = 0;
  endtask

  task automatic run_fail(input logic [1:0] sel, input logic [1:0] src, input logic wake,
                          input logic pll, input bit hold_clr);
    load(sel, src, wake, pll, 1);
    css_en = 1;
    repeat (40) @(negedge clk);
    check("R3 live clock no failure", nmi, 0);
    flag_clr = hold_clr;
    mon_run = 0;
    repeat (LIM + 8) @(negedge clk);
    flag_clr = 0;
    css_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset osc_en", osc_en, 0);
    check("R9 reset sys_sel", sys_sel, 0);
    check("R9 reset nmi/brk/pll", {nmi, brk, pll_en}, 0);
    rst = 0;

    load(2'd2, 2'd0, 1'b0, 1'b1, 0);
    check("R10 writes loaded", {osc_en, pll_en, sys_sel}, 4'b1110);

    repeat (40) @(negedge clk);
    check("R1 disabled keeps osc", osc_en, 1);
    check("R1 disabled no nmi", nmi, 0);

    begin
      int c = 0;
      css_en = 1;
      while (!nmi && c < 100) begin @(negedge clk); c++; end
      check("R2 arm plus window latency", c, ARM + LIM);
      check("R6 fallback to A", sys_sel, 0);
    end
    css_en = 0;

    begin
      int c = 0;
      load(2'd2, 2'd0, 1'b1, 1'b0, 0);
      css_en = 1;
      while (!nmi && c < 100) begin
        @(negedge clk); c++;
        if (c == 2) osc_rdy = 0;
        if (c == 3) osc_rdy = 1;
      end
      check("R2 ready glitch restarts delay", c, ARM + LIM + 3);
      check("R6 fallback to B", sys_sel, 1);
      repeat (5) @(negedge clk);
      check("R5 flag held", nmi, 1);
      flag_clr = 1; @(negedge clk); flag_clr = 0;
      check("R5 flag cleared", nmi, 0);
    end
    css_en = 0;

    run_fail(2'd3, 2'd3, 1'b0, 1'b1, 0);
    check("R7 pll off when feeding system", pll_en, 0);
    check("R6 pll path fallback", sys_sel, 0);

    run_fail(2'd3, 2'd1, 1'b1, 1'b1, 1);
    check("R8 select kept", sys_sel, 3);
    check("R7 internal-fed pll kept", pll_en, 1);
    check("R8 osc still off", osc_en, 0);

    run_fail(2'd1, 2'd2, 1'b0, 1'b1, 0);
    check("R7 xtal pll off system kept", pll_en, 1);
    check("R8 select kept B", sys_sel, 1);
    check("R5 flag set", nmi, 1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule